// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencing Control Unit

This block is the control sequencer for a processor datapath that spends several clock cycles on each instruction and reuses one ALU and one memory port across those cycles. It is a Moore state machine: every datapath strobe comes from the current state alone. It takes the opcode held in the instruction register, the ALU zero flag and the ALU overflow flag. From these it steps through fetch, decode and a path chosen by instruction class. Loads, stores, register-to-register operations, conditional branches and jumps each take their own number of cycles.

Two faults are handled by dedicated trap states. An opcode that is not recognised is caught after decode. An arithmetic overflow is caught after the register-to-register execute cycle, and the register write for that instruction does not happen. Each trap state records a cause code and saves the faulting instruction's address (the PC minus four, computed on the ALU). In the same cycle it redirects the PC to a fixed handler address. The machine then resumes fetching.

The ALU function decode of register-to-register instructions belongs to the datapath. This unit only signals "use the function field" for those instructions. One extra output combines the unconditional PC write with the conditional one and the zero flag, giving the PC register a single load enable.

Top module: `seq_ctrl_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the machine in the fetch state in the next cycle. This holds from power-up and also in the middle of an instruction.
- R2: The fetch state drives `mem_rd`=1, `ir_ld`=1, `pc_wr`=1, `addr_is_data`=0, `alu_a_sel`=0 (PC), `alu_b_sel`=01 (constant 4), `alu_op`=00 (add) and `pc_src`=00 (ALU result). Every strobe not named for a state, in this or any other requirement, is 0.
- R3: The decode state drives `alu_a_sel`=0, `alu_b_sel`=11 (shifted offset) and `alu_op`=00, and always follows fetch. Its successor is chosen by opcode: 0x00 register-to-register, 0x23 load, 0x2B store, 0x04 branch-if-equal, 0x02 jump. Any other value is undefined.
- R4: A load takes 5 cycles. After decode come address (`alu_a_sel`=1, `alu_b_sel`=10, `alu_op`=00), read (`mem_rd`=1, `addr_is_data`=1) and write-back (`reg_wr`=1, `wb_sel_mem`=1, `dst_is_rd`=0), then fetch.
- R5: A store takes 4 cycles. After decode come the address state and then write (`mem_wr`=1, `addr_is_data`=1), then fetch.
- R6: A register-to-register instruction takes 4 cycles when no overflow occurs. After decode come execute (`alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=10) and complete (`reg_wr`=1, `dst_is_rd`=1, `wb_sel_mem`=0), then fetch.
- R7: A branch takes 3 cycles. After decode comes one state with `alu_a_sel`=1, `alu_b_sel`=00, `alu_op`=01, `pc_wr_cond`=1 and `pc_src`=01, then fetch.
- R8: A jump takes 3 cycles. After decode comes one state with `pc_wr`=1 and `pc_src`=10, then fetch.
- R9: An undefined opcode in decode leads to a single trap cycle, then fetch. The trap drives `cause_ld`=1, `cause_code`=0, `epc_ld`=1, `alu_a_sel`=0, `alu_b_sel`=01, `alu_op`=01 (subtract), `pc_wr`=1 and `pc_src`=11 (handler address).
- R10: `alu_ovf` high in the execute state leads to the same trap cycle, but with `cause_code`=1 and no `reg_wr` for that instruction. `alu_ovf` is ignored in every other state.
- R11: `pc_en` is high when `pc_wr` is high, or when `pc_wr_cond` and `alu_zero` are both high, and is low otherwise.
- R12: Within a state, the strobes do not depend on `opcode`, `alu_zero` or `alu_ovf`. At most one of `mem_rd`, `mem_wr` and `reg_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| alu_ovf | input | 1 | ALU signed overflow flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the zero flag is set |
| pc_en | output | 1 | Combined PC load enable |
| addr_is_data | output | 1 | Memory address from ALU output register (1) or PC (0) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| wb_sel_mem | output | 1 | Register write data from memory data register (1) or ALU output (0) |
| ir_ld | output | 1 | Instruction register load |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU output register, 10 jump target, 11 handler |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 use function field |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 four, 10 offset, 11 offset shifted by two |
| reg_wr | output | 1 | Register file write |
| dst_is_rd | output | 1 | Destination register from rd field (1) or rt field (0) |
| epc_ld | output | 1 | Exception PC register load |
| cause_ld | output | 1 | Cause register load |
| cause_code | output | 1 | Cause value: 0 undefined opcode, 1 overflow |

## Verification
The bench builds two copies side by side with the default opcode encodings. One has `REG_STROBES`=1, where the strobes come from flops loaded with the decode of the next state. The other has `REG_STROBES`=0, where the strobes are decoded from the state register. Both copies are checked against the same expected sequence every cycle. This shows that the two output structures give identical cycle timing through every instruction path, both trap paths and a reset arriving in mid-instruction. The bench also toggles the flag inputs in states that must ignore them, which brings the Moore property and the overflow gating within reach.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;

    localparam int STATE_W = 4;
    localparam int SEL_W   = 2;
    localparam int CLASS_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH,
        ST_DECODE,
        ST_MEM_ADDR,
        ST_MEM_RD,
        ST_LOAD_WB,
        ST_MEM_WR,
        ST_R_EXEC,
        ST_R_DONE,
        ST_BR_DONE,
        ST_JMP_DONE,
        ST_TRAP_UNDEF,
        ST_TRAP_OVF
    } state_t;

    typedef enum logic [CLASS_W-1:0] {
        CL_RTYPE,
        CL_LOAD,
        CL_STORE,
        CL_BRANCH,
        CL_JUMP,
        CL_UNDEF
    } op_class_t;

    // PC source select
    localparam logic [SEL_W-1:0] PCS_ALU  = 2'd0;
    localparam logic [SEL_W-1:0] PCS_OUTR = 2'd1;
    localparam logic [SEL_W-1:0] PCS_JUMP = 2'd2;
    localparam logic [SEL_W-1:0] PCS_TRAP = 2'd3;

    // ALU operation request
    localparam logic [SEL_W-1:0] AOP_ADD   = 2'd0;
    localparam logic [SEL_W-1:0] AOP_SUB   = 2'd1;
    localparam logic [SEL_W-1:0] AOP_FUNCT = 2'd2;

    // ALU operand selects
    localparam logic ASEL_PC  = 1'b0;
    localparam logic ASEL_REG = 1'b1;
    localparam logic [SEL_W-1:0] BSEL_REG    = 2'd0;
    localparam logic [SEL_W-1:0] BSEL_FOUR   = 2'd1;
    localparam logic [SEL_W-1:0] BSEL_IMM    = 2'd2;
    localparam logic [SEL_W-1:0] BSEL_IMM_SH = 2'd3;

    // Cause codes
    localparam logic CAUSE_UNDEF = 1'b0;
    localparam logic CAUSE_OVF   = 1'b1;

    typedef struct packed {
        logic             pc_wr;
        logic             pc_wr_cond;
        logic             addr_is_data;
        logic             mem_rd;
        logic             mem_wr;
        logic             wb_sel_mem;
        logic             ir_ld;
        logic [SEL_W-1:0] pc_src;
        logic [SEL_W-1:0] alu_op;
        logic             alu_a_sel;
        logic [SEL_W-1:0] alu_b_sel;
        logic             reg_wr;
        logic             dst_is_rd;
        logic             epc_ld;
        logic             cause_ld;
        logic             cause_code;
    } strobes_t;

    typedef struct packed {
        state_t   st;
        strobes_t sb;
    } ctrl_t;

endpackage

// File: rtl/seq_ctrl_opdec.sv
module seq_ctrl_opdec
    import seq_ctrl_pkg::*;
#(
    parameter int              OP_W      = 6,
    parameter logic [OP_W-1:0] OP_RTYPE  = 6'h00,
    parameter logic [OP_W-1:0] OP_LOAD   = 6'h23,
    parameter logic [OP_W-1:0] OP_STORE  = 6'h2B,
    parameter logic [OP_W-1:0] OP_BRANCH = 6'h04,
    parameter logic [OP_W-1:0] OP_JUMP   = 6'h02
) (
    input  logic [OP_W-1:0] opcode,
    output op_class_t       cls
);

    always_comb begin
        if (opcode == OP_RTYPE) begin
            cls = CL_RTYPE;
        end else if (opcode == OP_LOAD) begin
            cls = CL_LOAD;
        end else if (opcode == OP_STORE) begin
            cls = CL_STORE;
        end else if (opcode == OP_BRANCH) begin
            cls = CL_BRANCH;
        end else if (opcode == OP_JUMP) begin
            cls = CL_JUMP;
        end else begin
            cls = CL_UNDEF;
        end
    end

endmodule

// File: rtl/seq_ctrl_next.sv
module seq_ctrl_next
    import seq_ctrl_pkg::*;
(
    input  state_t    cur,
    input  op_class_t cls,
    input  logic      ovf,
    output state_t    nxt
);

    always_comb begin
        nxt = ST_FETCH;
        unique case (cur)
            ST_FETCH: nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (cls)
                    CL_RTYPE:  nxt = ST_R_EXEC;
                    CL_LOAD:   nxt = ST_MEM_ADDR;
                    CL_STORE:  nxt = ST_MEM_ADDR;
                    CL_BRANCH: nxt = ST_BR_DONE;
                    CL_JUMP:   nxt = ST_JMP_DONE;
                    default:   nxt = ST_TRAP_UNDEF;
                endcase
            end
            ST_MEM_ADDR: nxt = (cls == CL_LOAD) ? ST_MEM_RD : ST_MEM_WR;
            ST_MEM_RD:   nxt = ST_LOAD_WB;
            // overflow is only acted on at the end of the execute cycle
            ST_R_EXEC:   nxt = ovf ? ST_TRAP_OVF : ST_R_DONE;
            default:     nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/seq_ctrl_strobes.sv
module seq_ctrl_strobes
    import seq_ctrl_pkg::*;
(
    input  state_t   st,
    output strobes_t sb
);

    always_comb begin
        sb = '0;
        unique case (st)
            ST_FETCH: begin
                sb.mem_rd    = 1'b1;
                sb.ir_ld     = 1'b1;
                sb.pc_wr     = 1'b1;
                sb.pc_src    = PCS_ALU;
                sb.alu_a_sel = ASEL_PC;
                sb.alu_b_sel = BSEL_FOUR;
                sb.alu_op    = AOP_ADD;
            end
            ST_DECODE: begin
                sb.alu_a_sel = ASEL_PC;
                sb.alu_b_sel = BSEL_IMM_SH;
                sb.alu_op    = AOP_ADD;
            end
            ST_MEM_ADDR: begin
                sb.alu_a_sel = ASEL_REG;
                sb.alu_b_sel = BSEL_IMM;
                sb.alu_op    = AOP_ADD;
            end
            ST_MEM_RD: begin
                sb.mem_rd       = 1'b1;
                sb.addr_is_data = 1'b1;
            end
            ST_LOAD_WB: begin
                sb.reg_wr     = 1'b1;
                sb.wb_sel_mem = 1'b1;
                sb.dst_is_rd  = 1'b0;
            end
            ST_MEM_WR: begin
                sb.mem_wr       = 1'b1;
                sb.addr_is_data = 1'b1;
            end
            ST_R_EXEC: begin
                sb.alu_a_sel = ASEL_REG;
                sb.alu_b_sel = BSEL_REG;
                sb.alu_op    = AOP_FUNCT;
            end
            ST_R_DONE: begin
                sb.reg_wr     = 1'b1;
                sb.dst_is_rd  = 1'b1;
                sb.wb_sel_mem = 1'b0;
            end
            ST_BR_DONE: begin
                sb.alu_a_sel  = ASEL_REG;
                sb.alu_b_sel  = BSEL_REG;
                sb.alu_op     = AOP_SUB;
                sb.pc_wr_cond = 1'b1;
                sb.pc_src     = PCS_OUTR;
            end
            ST_JMP_DONE: begin
                sb.pc_wr  = 1'b1;
                sb.pc_src = PCS_JUMP;
            end
            ST_TRAP_UNDEF, ST_TRAP_OVF: begin
                // ALU yields PC-4 for the saved address; PC takes the handler
                sb.alu_a_sel  = ASEL_PC;
                sb.alu_b_sel  = BSEL_FOUR;
                sb.alu_op     = AOP_SUB;
                sb.epc_ld     = 1'b1;
                sb.cause_ld   = 1'b1;
                sb.cause_code = (st == ST_TRAP_OVF) ? CAUSE_OVF : CAUSE_UNDEF;
                sb.pc_wr      = 1'b1;
                sb.pc_src     = PCS_TRAP;
            end
            default: sb = '0;
        endcase
    end

endmodule

// File: rtl/seq_ctrl_unit.sv
module seq_ctrl_unit
    import seq_ctrl_pkg::*;
#(
    parameter int              OP_W        = 6,
    parameter logic [OP_W-1:0] OP_RTYPE    = 6'h00,
    parameter logic [OP_W-1:0] OP_LOAD     = 6'h23,
    parameter logic [OP_W-1:0] OP_STORE    = 6'h2B,
    parameter logic [OP_W-1:0] OP_BRANCH   = 6'h04,
    parameter logic [OP_W-1:0] OP_JUMP     = 6'h02,
    parameter bit              REG_STROBES = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            alu_zero,
    input  logic            alu_ovf,
    output logic            pc_wr,
    output logic            pc_wr_cond,
    output logic            pc_en,
    output logic            addr_is_data,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            wb_sel_mem,
    output logic            ir_ld,
    output logic [1:0]      pc_src,
    output logic [1:0]      alu_op,
    output logic            alu_a_sel,
    output logic [1:0]      alu_b_sel,
    output logic            reg_wr,
    output logic            dst_is_rd,
    output logic            epc_ld,
    output logic            cause_ld,
    output logic            cause_code
);

    state_t    st_q;
    state_t    st_nxt;
    state_t    st_sel;
    op_class_t cls;
    strobes_t  sb;

    seq_ctrl_opdec #(
        .OP_W      (OP_W),
        .OP_RTYPE  (OP_RTYPE),
        .OP_LOAD   (OP_LOAD),
        .OP_STORE  (OP_STORE),
        .OP_BRANCH (OP_BRANCH),
        .OP_JUMP   (OP_JUMP)
    ) u_opdec (
        .opcode (opcode),
        .cls    (cls)
    );

    seq_ctrl_next u_next (
        .cur (st_q),
        .cls (cls),
        .ovf (alu_ovf),
        .nxt (st_nxt)
    );

    always_comb begin
        st_sel = rst ? ST_FETCH : st_nxt;
    end

    generate
        if (REG_STROBES) begin : g_reg_out
            ctrl_t    ctrl_d;
            ctrl_t    ctrl_q;
            strobes_t sb_nxt;

            seq_ctrl_strobes u_dec (
                .st (st_sel),
                .sb (sb_nxt)
            );

            always_comb begin
                ctrl_d.st = st_sel;
                ctrl_d.sb = sb_nxt;
            end

            always_ff @(posedge clk) begin
                ctrl_q <= ctrl_d;
            end

            assign st_q = ctrl_q.st;
            assign sb   = ctrl_q.sb;
        end else begin : g_dec_out
            state_t st_d;
            state_t st_r;

            always_comb begin
                st_d = st_sel;
            end

            always_ff @(posedge clk) begin
                st_r <= st_d;
            end

            assign st_q = st_r;

            seq_ctrl_strobes u_dec (
                .st (st_r),
                .sb (sb)
            );
        end
    endgenerate

    assign pc_wr        = sb.pc_wr;
    assign pc_wr_cond   = sb.pc_wr_cond;
    assign pc_en        = sb.pc_wr | (sb.pc_wr_cond & alu_zero);
    assign addr_is_data = sb.addr_is_data;
    assign mem_rd       = sb.mem_rd;
    assign mem_wr       = sb.mem_wr;
    assign wb_sel_mem   = sb.wb_sel_mem;
    assign ir_ld        = sb.ir_ld;
    assign pc_src       = sb.pc_src;
    assign alu_op       = sb.alu_op;
    assign alu_a_sel    = sb.alu_a_sel;
    assign alu_b_sel    = sb.alu_b_sel;
    assign reg_wr       = sb.reg_wr;
    assign dst_is_rd    = sb.dst_is_rd;
    assign epc_ld       = sb.epc_ld;
    assign cause_ld     = sb.cause_ld;
    assign cause_code   = sb.cause_code;

endmodule

// File: rtl/seq_ctrl_unit_chk.sv
module seq_ctrl_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       alu_ovf,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       addr_is_data,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       wb_sel_mem,
    input logic       ir_ld,
    input logic [1:0] pc_src,
    input logic [1:0] alu_op,
    input logic [1:0] alu_b_sel,
    input logic       reg_wr,
    input logic       epc_ld,
    input logic       cause_ld,
    input logic       cause_code
);

    p_fetch_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ir_ld && mem_rd && pc_wr && !addr_is_data));

    p_decode_after_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        ir_ld |=> (alu_b_sel == 2'b11 && !ir_ld));

    p_load_wb_after_read_r4: assert property (@(posedge clk) disable iff (rst)
        wb_sel_mem |-> $past(mem_rd && addr_is_data));

    p_branch_returns_r7: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |=> ir_ld);

    p_undef_from_decode_r9: assert property (@(posedge clk) disable iff (rst)
        (cause_ld && !cause_code) |-> $past(alu_b_sel == 2'b11));

    p_trap_redirect_r9: assert property (@(posedge clk) disable iff (rst)
        cause_ld |-> (epc_ld && pc_wr && pc_src == 2'b11 && alu_op == 2'b01));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 2'b10 && alu_ovf) |=> (cause_ld && cause_code && !reg_wr));

    p_single_access_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr, reg_wr}));

endmodule

bind seq_ctrl_unit seq_ctrl_unit_chk u_chk (.*);

// File: tb/seq_ctrl_unit_test.sv
module seq_ctrl_unit_test;

    localparam int CLK_PERIOD = 10;

    localparam logic [5:0] OPC_R   = 6'h00;
    localparam logic [5:0] OPC_LW  = 6'h23;
    localparam logic [5:0] OPC_SW  = 6'h2B;
    localparam logic [5:0] OPC_BEQ = 6'h04;
    localparam logic [5:0] OPC_J   = 6'h02;

    localparam int S_IF  = 0;
    localparam int S_ID  = 1;
    localparam int S_MA  = 2;
    localparam int S_MR  = 3;
    localparam int S_LWB = 4;
    localparam int S_MW  = 5;
    localparam int S_RX  = 6;
    localparam int S_RD  = 7;
    localparam int S_BR  = 8;
    localparam int S_JP  = 9;
    localparam int S_TU  = 10;
    localparam int S_TO  = 11;

    typedef struct packed {
        logic       pcw;
        logic       pcc;
        logic       pcen;
        logic       iord;
        logic       mrd;
        logic       mwr;
        logic       m2r;
        logic       irw;
        logic [1:0] psrc;
        logic [1:0] aop;
        logic       asel;
        logic [1:0] bsel;
        logic       rw;
        logic       rdst;
        logic       epc;
        logic       cw;
        logic       cv;
    } vec_t;

    typedef struct {
        vec_t  v;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h3F;
    logic       alu_zero = 1'b0;
    logic       alu_ovf = 1'b0;

    vec_t obs_a;
    vec_t obs_b;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    item_t exp_q[$];
    item_t cur;

    always #(CLK_PERIOD / 2) clk = ~clk;

    seq_ctrl_unit #(.REG_STROBES(1'b1)) uut (
        .clk (clk), .rst (rst), .opcode (opcode),
        .alu_zero (alu_zero), .alu_ovf (alu_ovf),
        .pc_wr (obs_a.pcw), .pc_wr_cond (obs_a.pcc), .pc_en (obs_a.pcen),
        .addr_is_data (obs_a.iord), .mem_rd (obs_a.mrd), .mem_wr (obs_a.mwr),
        .wb_sel_mem (obs_a.m2r), .ir_ld (obs_a.irw), .pc_src (obs_a.psrc),
        .alu_op (obs_a.aop), .alu_a_sel (obs_a.asel), .alu_b_sel (obs_a.bsel),
        .reg_wr (obs_a.rw), .dst_is_rd (obs_a.rdst), .epc_ld (obs_a.epc),
        .cause_ld (obs_a.cw), .cause_code (obs_a.cv)
    );

    seq_ctrl_unit #(.REG_STROBES(1'b0)) uut_comb (
        .clk (clk), .rst (rst), .opcode (opcode),
        .alu_zero (alu_zero), .alu_ovf (alu_ovf),
        .pc_wr (obs_b.pcw), .pc_wr_cond (obs_b.pcc), .pc_en (obs_b.pcen),
        .addr_is_data (obs_b.iord), .mem_rd (obs_b.mrd), .mem_wr (obs_b.mwr),
        .wb_sel_mem (obs_b.m2r), .ir_ld (obs_b.irw), .pc_src (obs_b.psrc),
        .alu_op (obs_b.aop), .alu_a_sel (obs_b.asel), .alu_b_sel (obs_b.bsel),
        .reg_wr (obs_b.rw), .dst_is_rd (obs_b.rdst), .epc_ld (obs_b.epc),
        .cause_ld (obs_b.cw), .cause_code (obs_b.cv)
    );

    // Expected strobes per state, taken from the requirements
    function automatic vec_t expect_of(input int s, input logic z);
        vec_t e;
        e = '0;
        case (s)
            S_IF: begin
                e.mrd = 1'b1; e.irw = 1'b1; e.pcw = 1'b1; e.bsel = 2'b01; e.pcen = 1'b1;
            end
            S_ID:  e.bsel = 2'b11;
            S_MA:  begin e.asel = 1'b1; e.bsel = 2'b10; end
            S_MR:  begin e.mrd = 1'b1; e.iord = 1'b1; end
            S_LWB: begin e.rw = 1'b1; e.m2r = 1'b1; end
            S_MW:  begin e.mwr = 1'b1; e.iord = 1'b1; end
            S_RX:  begin e.asel = 1'b1; e.aop = 2'b10; end
            S_RD:  begin e.rw = 1'b1; e.rdst = 1'b1; end
            S_BR: begin
                e.asel = 1'b1; e.aop = 2'b01; e.pcc = 1'b1; e.psrc = 2'b01; e.pcen = z;
            end
            S_JP:  begin e.pcw = 1'b1; e.psrc = 2'b10; e.pcen = 1'b1; end
            S_TU, S_TO: begin
                e.bsel = 2'b01; e.aop = 2'b01; e.epc = 1'b1; e.cw = 1'b1;
                e.pcw = 1'b1; e.psrc = 2'b11; e.pcen = 1'b1;
                e.cv = (s == S_TO);
            end
            default: e = '0;
        endcase
        return e;
    endfunction

    // Driver: set inputs for the current cycle, queue the expected strobes
    task automatic step(input logic [5:0] op, input logic ovf, input logic z,
                        input int s, input string tag);
        item_t it;
        opcode   = op;
        alu_ovf  = ovf;
        alu_zero = z;
        it.v     = expect_of(s, z);
        it.tag   = tag;
        exp_q.push_back(it);
        @(posedge clk);
        #1;
    endtask

    // Fetch with junk opcode and flags: strobes must not react (R12)
    task automatic fetch_step();
        step(6'h3F, 1'b1, 1'b0, S_IF, "R2 R12");
    endtask

    task automatic do_lw(input logic z);
        fetch_step();
        step(OPC_LW, 1'b0, 1'b0, S_ID, "R3");
        step(OPC_LW, 1'b1, z, S_MA, "R4 R10 R11");
        step(OPC_LW, 1'b0, 1'b0, S_MR, "R4");
        step(OPC_LW, 1'b0, 1'b0, S_LWB, "R4");
    endtask

    task automatic do_sw();
        fetch_step();
        step(OPC_SW, 1'b0, 1'b0, S_ID, "R3");
        step(OPC_SW, 1'b0, 1'b0, S_MA, "R5");
        step(OPC_SW, 1'b1, 1'b1, S_MW, "R5 R12");
    endtask

    task automatic do_r(input logic ovf, input logic z);
        fetch_step();
        step(OPC_R, 1'b0, 1'b0, S_ID, "R3");
        step(OPC_R, ovf, z, S_RX, "R6 R11");
        if (ovf) step(OPC_R, 1'b0, 1'b0, S_TO, "R10");
        else     step(OPC_R, 1'b0, 1'b0, S_RD, "R6");
    endtask

    task automatic do_beq(input logic z);
        fetch_step();
        step(OPC_BEQ, 1'b0, 1'b0, S_ID, "R3");
        step(OPC_BEQ, 1'b0, z, S_BR, "R7 R11");
    endtask

    task automatic do_j();
        fetch_step();
        step(OPC_J, 1'b0, 1'b0, S_ID, "R3");
        step(OPC_J, 1'b1, 1'b1, S_JP, "R8");
    endtask

    task automatic do_undef(input logic [5:0] op);
        fetch_step();
        step(op, 1'b0, 1'b0, S_ID, "R3");
        step(op, 1'b0, 1'b0, S_TU, "R9");
    endtask

    task automatic compare(input vec_t got, input vec_t want, input string tag,
                           input string who);
        n_checks++;
        if (got !== want) begin
            n_fails++;
            $display("FAIL %s (%s): got %h expected %h", tag, who, got, want);
        end
    endtask

    // Monitor: pop one expected item per cycle and compare both copies
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            compare(obs_a, cur.v, cur.tag, "uut");
            compare(obs_b, cur.v, cur.tag, "uut_comb");
        end
    end

    initial begin
        @(posedge clk);
        #1;
        // reset still high: fetch state is held (R1)
        step(6'h3F, 1'b0, 1'b0, S_IF, "R1");
        rst = 1'b0;
        do_lw(1'b1);
        do_sw();
        do_r(1'b0, 1'b1);
        do_r(1'b1, 1'b0);
        do_beq(1'b1);
        do_beq(1'b0);
        do_j();
        do_undef(6'h3F);
        do_undef(6'h05);
        // reset in the middle of a store: fetch follows (R1)
        fetch_step();
        step(OPC_SW, 1'b0, 1'b0, S_ID, "R3");
        rst = 1'b1;
        step(OPC_SW, 1'b0, 1'b0, S_MA, "R1");
        rst = 1'b0;
        do_r(1'b0, 1'b0);
        do_lw(1'b0);
        do_j();
        fetch_step();
        @(negedge clk);
        #1;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule